// File: doc/BRIEF.md
# Partial-reconfiguration load controller

This block is the device-side register front end for loading a partial-reconfiguration image into one region of the device. A host reaches it through a simple 64-bit register bus. The bus has a single-cycle write strobe and read data that is decoded combinationally from the address. Through these registers the host runs a reset handshake, selects a target region and starts a load. It then streams image words into an internal FIFO, paced by a credit count that the block publishes, and finally marks the end of the image. A modelled configuration engine drains the FIFO over a valid/ready stream. Once the engine is empty and has finished, the block releases the start request by itself.

The sequencing is held by a four-state machine. RESETTING is entered from any state when the host reset request is set, and it is left for IDLE when the request is cleared. IDLE moves to LOADING once a start request is accepted. LOADING moves to DRAINING when the host sets push-complete. DRAINING returns to IDLE when the FIFO is empty and the engine has spent its finish latency. The state code appears in the status register: IDLE=0, RESETTING=1, LOADING=2, DRAINING=3. Faults latch into an error register, and the host clears them by writing ones.

Register map (word address on `bus_addr`):
- 0, identity, read-only: [3:0] revision, [15:8] bytes per image word, [19:16] number of regions.
- 1, control: [0] reset request, [4] reset acknowledge (read-only), [8] start request, [9] push complete, [15:12] region.
- 2, status, read-only: [7:0] credit, [17:16] state code, [24] error summary.
- 3, error, write-one-to-clear: [0] overflow, [1] protocol.
- 4, data, write-only: [31:0] image word.

Top module: `prl_ctrl`

## Requirements
- R1: After reset, status reads credit 16, state code 0 and summary 0. Control reads 0 and error reads 0.
- R2: Writing control[0]=1 moves the state to code 1 and sets control[4]. The FIFO is emptied, so credit reads 16. Writing control[0]=0 returns the state to code 0 and clears control[4].
- R3: A control write in IDLE with [8]=1 and a region below the region count sets control[8] and latches the region into control[15:12] and `load_region`. The state then becomes code 2 and `load_active` rises.
- R4: A start write whose region is not below the region count sets error[1] and leaves control[8] at 0 and the state at code 0.
- R5: Credit equals the FIFO depth minus its occupancy. Each accepted data write lowers it by one, and each word taken by the engine raises it by one.
- R6: In LOADING, a data write enters bits [31:0] into the FIFO and ignores bits [63:32]. Words leave on `eng_word` in write order while `eng_valid` is high, one per cycle with `eng_ready` high.
- R7: A data write in LOADING when credit is 0 sets error[0] and the word is dropped.
- R8: A data write outside LOADING sets error[1] and leaves credit unchanged.
- R9: Writing the error register clears exactly the bits written as one.
- R10: Status[24] is 1 exactly when some error bit is set.
- R11: Setting control[9] in LOADING moves the state to code 3. When the FIFO is empty and the finish latency has passed, control[8] and control[9] clear by themselves, the state returns to 0 and `load_active` falls.
- R12: The identity register reports revision 1, 4 bytes per word and 5 regions at default parameters. Revision 2 selects 64-byte words built from eight data beats.
- R13: A reset request during a load clears control[8] and discards the FIFO contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr |
| load_region | output | REG_W | Region latched at start |
| load_active | output | 1 | High in LOADING and DRAINING |
| eng_ready | input | 1 | Engine accepts a word |
| eng_valid | output | 1 | FIFO head offered to engine |
| eng_word | output | WORD_W | FIFO head word |

## Verification
The bench fills the FIFO with the engine stalled and then pushes one more word. A design that wrapped its occupancy or lacked the overflow check would report a nonzero credit or later emit the extra word. It starts with an out-of-range region and pushes data while idle. A design that skipped these checks would begin a load or take the word with no error flagged. Random push and drain traffic with random ready compares every offered word and the final credit against a bench queue, which catches slips in pointer or credit arithmetic. A reset in the middle of a load and a drain-to-idle completion are also run: a design that kept start set or left stale FIFO words behind would read back the wrong control bits or credit.

// File: rtl/prl_pkg.sv
package prl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DRAIN = 2'd3
    } prl_state_e;

    localparam logic [2:0] ADR_HDR  = 3'd0;
    localparam logic [2:0] ADR_CTRL = 3'd1;
    localparam logic [2:0] ADR_STAT = 3'd2;
    localparam logic [2:0] ADR_ERR  = 3'd3;
    localparam logic [2:0] ADR_DATA = 3'd4;

    localparam int CB_RST_REQ = 0;
    localparam int CB_RST_ACK = 4;
    localparam int CB_START   = 8;
    localparam int CB_PUSHED  = 9;
    localparam int CB_REGION  = 12;

    localparam int SB_STATE = 16;
    localparam int SB_ERR   = 24;

    localparam int ERR_N     = 2;
    localparam int EB_OVF    = 0;
    localparam int EB_PROTO  = 1;

endpackage

// File: rtl/prl_fifo.sv
module prl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rp];

endmodule

// File: rtl/prl_engine.sv
module prl_engine #(
    parameter int W       = 32,
    parameter int FIN_LAT = 3,
    localparam int LAT_W  = $clog2(FIN_LAT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         finishing,
    input  logic         empty,
    input  logic [W-1:0] head,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] word,
    output logic         pop,
    output logic         fin_done
);

    logic [LAT_W-1:0] lat_cnt;

    assign valid    = active && !empty;
    assign word     = head;
    assign pop      = valid && ready;
    assign fin_done = finishing && empty && (lat_cnt == LAT_W'(FIN_LAT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !finishing || !empty) lat_cnt <= '0;
        else if (!fin_done)                 lat_cnt <= lat_cnt + 1'b1;
    end

endmodule

// File: rtl/prl_fsm.sv
module prl_fsm
    import prl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       start,
    input  logic       pushed,
    input  logic       fin_done,
    output prl_state_e state,
    output logic       rst_ack,
    output logic       flush,
    output logic       load_open,
    output logic       active,
    output logic       finishing,
    output logic       clear_start
);

    prl_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)    nxt = ST_LOAD;
            ST_RESET: if (!rst_req) nxt = ST_IDLE;
            ST_LOAD:  if (pushed)   nxt = ST_DRAIN;
            ST_DRAIN: if (fin_done) nxt = ST_IDLE;
        endcase
        if (rst_req) nxt = ST_RESET;
    end

    always_comb begin
        rst_ack     = 1'b0;
        flush       = 1'b0;
        load_open   = 1'b0;
        active      = 1'b0;
        finishing   = 1'b0;
        clear_start = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RESET: begin
                rst_ack = 1'b1;
                flush   = 1'b1;
            end
            ST_LOAD: begin
                load_open = 1'b1;
                active    = 1'b1;
            end
            ST_DRAIN: begin
                active      = 1'b1;
                finishing   = 1'b1;
                clear_start = fin_done && !rst_req;
            end
        endcase
    end

endmodule

// File: rtl/prl_ctrl.sv
module prl_ctrl
    import prl_pkg::*;
#(
    parameter int HDR_REV   = 1,
    parameter int DEPTH     = 16,
    parameter int NUM_PORTS = 5,
    parameter int REG_W     = 4,
    parameter int FIN_LAT   = 3,
    localparam int WORD_BYTES = (HDR_REV == 2) ? 64 : 4,
    localparam int WORD_W     = WORD_BYTES * 8,
    localparam int BEATS      = (HDR_REV == 2) ? 8 : 1,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic [REG_W-1:0]  load_region,
    output logic              load_active,
    input  logic              eng_ready,
    output logic              eng_valid,
    output logic [WORD_W-1:0] eng_word
);

    prl_state_e         state;
    logic               rst_req_q, start_q, push_q;
    logic [REG_W-1:0]   region_q;
    logic [ERR_N-1:0]   err_q, err_nxt;
    logic               rst_ack, flush, load_open, active, finishing, clear_start;
    logic               fin_done, eng_pop, fifo_push;
    logic [CNT_W-1:0]   fifo_cnt, credit;
    logic [WORD_W-1:0]  fifo_head, word_val;
    logic               word_commit;
    logic               wr_ctrl, wr_err, wr_data;
    logic [REG_W-1:0]   new_region;
    logic               region_ok, start_try, ovf_evt, proto_evt;
    logic               unused_bits;

    assign wr_ctrl    = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_err     = bus_wr && (bus_addr == ADR_ERR);
    assign wr_data    = bus_wr && (bus_addr == ADR_DATA);
    assign new_region = bus_wdata[CB_REGION +: REG_W];
    assign region_ok  = (32'(new_region) < NUM_PORTS);
    assign start_try  = wr_ctrl && !bus_wdata[CB_RST_REQ] && bus_wdata[CB_START]
                        && (state == ST_IDLE) && !start_q;
    assign credit     = CNT_W'(DEPTH) - fifo_cnt;

    generate
        if (BEATS == 1) begin : g_narrow
            assign word_commit = wr_data && load_open;
            assign word_val    = bus_wdata[WORD_W-1:0];
        end else begin : g_wide
            localparam int BC_W = $clog2(BEATS);
            logic [WORD_W-65:0] beat_buf;
            logic [BC_W-1:0]    beat_cnt;
            assign word_commit = wr_data && load_open && (beat_cnt == BC_W'(BEATS - 1));
            assign word_val    = {bus_wdata, beat_buf};
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    beat_cnt <= '0;
                    beat_buf <= '0;
                end else if (wr_data && load_open) begin
                    beat_cnt <= word_commit ? '0 : beat_cnt + 1'b1;
                    beat_buf <= {bus_wdata, beat_buf[WORD_W-65:64]};
                end
            end
        end
    endgenerate

    assign fifo_push = word_commit && (credit != '0);
    assign ovf_evt   = word_commit && (credit == '0);
    assign proto_evt = (wr_data && !load_open) || (start_try && !region_ok);

    prl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req_q), .start(start_q),
        .pushed(push_q), .fin_done(fin_done), .state(state), .rst_ack(rst_ack),
        .flush(flush), .load_open(load_open), .active(active),
        .finishing(finishing), .clear_start(clear_start)
    );

    prl_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(fifo_push),
        .din(word_val), .pop(eng_pop), .dout(fifo_head), .count(fifo_cnt)
    );

    prl_engine #(.W(WORD_W), .FIN_LAT(FIN_LAT)) u_eng (
        .clk(clk), .rst_n(rst_n), .active(active), .finishing(finishing),
        .empty(fifo_cnt == '0), .head(fifo_head), .ready(eng_ready),
        .valid(eng_valid), .word(eng_word), .pop(eng_pop), .fin_done(fin_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            start_q   <= 1'b0;
            push_q    <= 1'b0;
            region_q  <= '0;
        end else begin
            if (wr_ctrl) rst_req_q <= bus_wdata[CB_RST_REQ];
            if (flush || clear_start) begin
                start_q <= 1'b0;
                push_q  <= 1'b0;
            end else begin
                if (start_try && region_ok) begin
                    start_q  <= 1'b1;
                    region_q <= new_region;
                end
                if (wr_ctrl && bus_wdata[CB_PUSHED] && (state == ST_LOAD))
                    push_q <= 1'b1;
            end
        end
    end

    always_comb begin
        err_nxt = err_q;
        if (wr_err) err_nxt = err_nxt & ~bus_wdata[ERR_N-1:0];
        if (ovf_evt)   err_nxt[EB_OVF]   = 1'b1;
        if (proto_evt) err_nxt[EB_PROTO] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_nxt;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_HDR: begin
                bus_rdata[3:0]   = 4'(HDR_REV);
                bus_rdata[15:8]  = 8'(WORD_BYTES);
                bus_rdata[19:16] = 4'(NUM_PORTS);
            end
            ADR_CTRL: begin
                bus_rdata[CB_RST_REQ]            = rst_req_q;
                bus_rdata[CB_RST_ACK]            = rst_ack;
                bus_rdata[CB_START]              = start_q;
                bus_rdata[CB_PUSHED]             = push_q;
                bus_rdata[CB_REGION +: REG_W]    = region_q;
            end
            ADR_STAT: begin
                bus_rdata[7:0]             = 8'(credit);
                bus_rdata[SB_STATE +: 2]   = state;
                bus_rdata[SB_ERR]          = |err_q;
            end
            ADR_ERR:  bus_rdata[ERR_N-1:0] = err_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign load_region = region_q;
    assign load_active = active;
    assign unused_bits = ^bus_wdata;

endmodule

// File: rtl/prl_ctrl_chk.sv
module prl_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req_q,
    input logic             rst_ack,
    input logic [CNT_W-1:0] credit,
    input logic             fifo_push,
    input logic             eng_pop,
    input logic             flush,
    input logic             start_q,
    input logic             clear_start,
    input logic             wr_data,
    input logic             load_open,
    input logic [1:0]       err_q
);

    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_q) |=> rst_ack);

    a_r5_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CNT_W'(DEPTH));

    a_r5_credit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !eng_pop && !flush) |=> (credit == $past(credit) - 1'b1));

    a_r8_proto_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !load_open) |=> err_q[1]);

    a_r11_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_q) |-> ($past(clear_start) || $past(flush)));

endmodule

bind prl_ctrl prl_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req_q(rst_req_q), .rst_ack(rst_ack),
    .credit(credit), .fifo_push(fifo_push), .eng_pop(eng_pop), .flush(flush),
    .start_q(start_q), .clear_start(clear_start), .wr_data(wr_data),
    .load_open(load_open), .err_q(err_q)
);

// File: tb/sim_prl_ctrl.sv
`timescale 1ns/1ps
module sim_prl_ctrl;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [3:0]  load_region;
    logic        load_active;
    logic        eng_ready = 1'b0;
    logic        eng_valid;
    logic [31:0] eng_word;

    int total = 0;
    int bad = 0;
    bit ended = 0;
    logic [31:0] q[$];

    always #2 clk = ~clk;

    prl_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_region(load_region),
        .load_active(load_active), .eng_ready(eng_ready), .eng_valid(eng_valid),
        .eng_word(eng_word)
    );

    function automatic logic [63:0] ctl(input bit rr, input bit st, input bit pd, input int rg);
        return 64'(rr) | (64'(st) << 8) | (64'(pd) << 9) | (64'(rg & 15) << 12);
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd7));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1, R12 reset state and identity
        rd(3'd0, d); chk(d, 64'h0005_0401, "R12 identity");
        rd(3'd2, d); chk(d, 64'd16, "R1 status after reset");
        rd(3'd1, d); chk(d, 64'd0, "R1 control after reset");
        rd(3'd3, d); chk(d, 64'd0, "R1 error after reset");

        // R8 data write while idle
        wr(3'd4, 64'h1234);
        rd(3'd3, d); chk(d, 64'd2, "R8 protocol flag");
        rd(3'd2, d); chk(d, 64'h0100_0010, "R8 R10 credit kept, summary set");

        // R9 write-one-to-clear
        wr(3'd3, 64'h1);
        rd(3'd3, d); chk(d, 64'd2, "R9 zero bits untouched");
        wr(3'd3, 64'h2);
        rd(3'd3, d); chk(d, 64'd0, "R9 cleared");
        rd(3'd2, d); chk(d[24], 1'b0, "R10 summary clear");

        // R4 region out of range
        wr(3'd1, ctl(0, 1, 0, 7));
        step(1);
        rd(3'd3, d); chk(d, 64'd2, "R4 protocol flag");
        rd(3'd1, d); chk(d[8], 1'b0, "R4 start not taken");
        rd(3'd2, d); chk(d[17:16], 2'd0, "R4 still idle");
        wr(3'd3, 64'h3);

        // R2 reset handshake
        wr(3'd1, ctl(1, 0, 0, 0));
        step(1);
        rd(3'd1, d); chk(d[4], 1'b1, "R2 ack set");
        rd(3'd2, d); chk(d[17:16], 2'd1, "R2 resetting code");
        wr(3'd1, ctl(0, 0, 0, 0));
        step(1);
        rd(3'd2, d); chk(d[17:16], 2'd0, "R2 back to idle");
        rd(3'd1, d); chk(d[4], 1'b0, "R2 ack cleared");

        // R3 start a load
        wr(3'd1, ctl(0, 1, 0, 3));
        step(1);
        rd(3'd1, d); chk({d[15:12], d[8]}, 5'b0011_1, "R3 control region/start");
        rd(3'd2, d); chk(d[17:16], 2'd2, "R3 loading code");
        chk({load_region, load_active}, 5'b0011_1, "R3 port outputs");

        // R5 R7 fill with engine stalled, then overflow
        eng_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) wr(3'd4, {32'hFFFF_0000 | 32'(i), 32'hA500_0000 + 32'(i)});
        rd(3'd2, d); chk(d[7:0], 8'd0, "R5 credit exhausted");
        wr(3'd4, {32'h0, 32'h0BAD_0BAD});
        rd(3'd3, d); chk(d, 64'd1, "R7 overflow flag");
        rd(3'd2, d); chk({d[24], d[7:0]}, 9'h100, "R7 R10 credit zero, summary");
        wr(3'd3, 64'h1);

        // R6 drain in order, upper bits ignored, overflow word absent
        @(negedge clk);
        eng_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            #1 chk({eng_valid, eng_word}, {1'b1, 32'hA500_0000 + 32'(i)}, "R6 word order");
            @(negedge clk);
        end
        #1 chk(eng_valid, 1'b0, "R7 dropped word absent");
        eng_ready = 1'b0;
        rd(3'd2, d); chk(d[7:0], 8'd16, "R5 credit restored");

        // R5 R6 random push/drain traffic
        for (int c = 0; c < 400; c++) begin
            bit r, w;
            logic [31:0] wd;
            @(negedge clk);
            r = 1'($urandom % 2);
            w = (q.size() < DEPTH) && ($urandom % 3 != 0);
            wd = $urandom;
            eng_ready = r; bus_wr = w; bus_addr = 3'd4; bus_wdata = {$urandom, wd};
            #1;
            chk(eng_valid, q.size() != 0, "R6 random valid");
            if (q.size() != 0) chk(eng_word, q[0], "R6 random word");
            if (r && q.size() != 0) void'(q.pop_front());
            if (w) q.push_back(wd);
        end
        @(negedge clk);
        bus_wr = 1'b0;
        for (int i = 0; q.size() != 0 && i < 40; i++) begin
            eng_ready = 1'b1;
            #1 chk(eng_word, q[0], "R6 tail word");
            void'(q.pop_front());
            @(negedge clk);
        end
        eng_ready = 1'b0;
        rd(3'd2, d); chk(d[7:0], 8'd16, "R5 credit after random");
        rd(3'd3, d); chk(d, 64'd0, "R5 no stray errors");

        // R11 push complete and release
        wr(3'd4, 64'h11);
        wr(3'd4, 64'h22);
        wr(3'd1, ctl(0, 1, 1, 3));
        step(1);
        rd(3'd2, d); chk(d[17:16], 2'd3, "R11 draining code");
        rd(3'd1, d); chk(d[9:8], 2'b11, "R11 start and push held");
        eng_ready = 1'b1;
        step(20);
        eng_ready = 1'b0;
        rd(3'd2, d); chk({d[17:16], d[7:0]}, {2'd0, 8'd16}, "R11 idle again");
        rd(3'd1, d); chk(d[9:8], 2'b00, "R11 start self-cleared");
        chk(load_active, 1'b0, "R11 load_active low");

        // R13 reset during a load
        wr(3'd1, ctl(0, 1, 0, 4));
        step(1);
        for (int i = 0; i < 3; i++) wr(3'd4, 64'(i));
        wr(3'd1, ctl(1, 0, 0, 4));
        step(2);
        rd(3'd1, d); chk({d[8], d[4]}, 2'b01, "R13 start dropped, ack up");
        rd(3'd2, d); chk({d[17:16], d[7:0]}, {2'd1, 8'd16}, "R13 R2 FIFO flushed");
        wr(3'd1, 64'd0);
        step(1);
        rd(3'd2, d); chk(d[17:16], 2'd0, "R2 idle after release");
        chk(eng_valid, 1'b0, "R13 nothing offered");

        finish_run();
    end

endmodule